// File: doc/BRIEF.md
# Privilege-Aware Interrupt Priority Selector

This block holds one pending flag for each interrupt class a core can receive. Sources post a class by code, and each post sets that class's flag. When the core raises a take request, the block looks at the current processor state and names, in the same cycle, the one class that may be taken. The state it reads is the hypervisor-privilege flag, the trap-level-zero enable, the trap level, the hypervisor pending register, the processor interrupt level and the software-interrupt register. The flag of the chosen class is consumed at the next clock edge.

The ranking depends on privilege. Under hypervisor privilege only two classes compete. Otherwise six classes are ranked in a fixed order, and several of them are gated by side conditions. A class whose condition fails is skipped, and the search moves on to the next class. A software interrupt is ranked by its level, which is the highest set bit of the software-interrupt register. That level must exceed the processor interrupt level. The software pending flag stays set while any other level remains requested.

Top module: `irq_prio_sel`

## Requirements
- R1: Class codes are: 0 hypervisor tick, 1 platform vector, 2 trap-level-zero, 3 CPU queue, 4 device queue, 5 software, 6 resumable error. A post with a code of 0 to 6 sets that flag. A post with code 7 sets nothing and raises `post_err` in the same cycle. A legal post leaves `post_err` low.
- R2: The grant is combinational in the cycle of `take_req`. With `take_req` low, or with no class takeable, `grant_valid`, `grant_cause` and `grant_level` are all 0.
- R3: With `hpriv` high, only two classes can be granted: hypervisor tick first, then platform vector. All other pending classes are ignored.
- R4: With `hpriv` low, the order is trap-level-zero, hypervisor tick, CPU queue, device queue, software, resumable error. The platform vector is never granted in this mode.
- R5: Hypervisor tick is granted only while `hv_pend[0]` is 1. Trap-level-zero is granted only while `tlz_en` is 1 and `trap_level` is 0. If a gated class fails its condition, the next class in the order is granted instead.
- R6: The software level is the index of the highest set bit among `soft_reg[15:1]`, and bit 0 is ignored. A software interrupt is granted only when that level is strictly greater than `proc_level`. On a software grant, `grant_level` carries the level. For any other class, `grant_level` is 0.
- R7: After a software grant, the software flag is cleared only if no bit of `soft_reg[15:1]` other than the granted level is set. Otherwise the flag stays pending.
- R8: Granting any other class clears that class's flag at the clock edge, so one post yields exactly one grant.
- R9: When a post and a grant of the same class fall in the same cycle, the post wins and the class stays pending.
- R10: Synchronous active-low reset clears all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| post_valid | input | 1 | Post strobe |
| post_class | input | 3 | Class code being posted |
| post_err | output | 1 | Posted code is not a known class |
| take_req | input | 1 | Core asks for an interrupt this cycle |
| hpriv | input | 1 | Hypervisor-privileged mode |
| tlz_en | input | 1 | Trap-level-zero enable |
| trap_level | input | 3 | Current trap level |
| hv_pend | input | 16 | Hypervisor pending register (bit 0 gates the tick) |
| proc_level | input | 4 | Processor interrupt level threshold |
| soft_reg | input | 16 | Software-interrupt register |
| grant_valid | output | 1 | A class was chosen |
| grant_cause | output | 3 | Code of the chosen class |
| grant_level | output | 4 | Software level of the grant, else 0 |

## Verification
A flag that is stuck or lost inside the block shows at the ports only on the next take request that reaches its rank. A lost flag appears as a missing or lower-ranked grant. A stuck flag appears as a repeated grant one cycle after the first. For that reason, every scenario drains its posted classes one request at a time and ends with a request that must find nothing. A software flag that is cleared too early or too late shows as a missing or extra grant when the remaining levels are requested. The bench therefore changes the software register between requests and checks both outcomes.

// File: rtl/irq_prio_pkg.sv
// Shared class codes and counts for the interrupt priority selector.
// Assumes at most 8 classes so that a 3-bit code covers them.
package irq_prio_pkg;
    localparam int NUM_CLASSES = 7;
    localparam int CW          = 3;

    typedef enum logic [CW-1:0] {
        C_TICK = 3'd0,
        C_VEC  = 3'd1,
        C_TLZ  = 3'd2,
        C_CPUQ = 3'd3,
        C_DEVQ = 3'd4,
        C_SOFT = 3'd5,
        C_RERR = 3'd6
    } cause_e;
endpackage

// File: rtl/irq_pend_bank.sv
// Pending flag store: one flag per class, set by a post and cleared by
// a consume mask. Assumes the caller has already rejected illegal codes.
// A set and a clear of the same flag in one cycle leaves it set.
module irq_pend_bank #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_mask,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] pend
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // One flag: reset clears it, a set beats a clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend[i] <= 1'b0;
            else if (set_mask[i])
                pend[i] <= 1'b1;
            else if (clr_mask[i])
                pend[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_level_enc.sv
// Highest-set-bit encoder over vec[W-1:1]. Bit 0 is ignored, so an output
// of 0 means no level is requested. Purely combinational.
module irq_level_enc #(
    parameter  int W  = 16,
    localparam int LW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [LW-1:0] lvl
);
    // Scan upward so that the last set bit found is the highest one.
    always_comb begin
        lvl = '0;
        for (int i = 1; i < W; i++) begin
            if (vec[i])
                lvl = LW'(i);
        end
    end
endmodule

// File: rtl/irq_sel_core.sv
// Combinational choice of one class from the pending flags and processor
// state, plus the consume mask applied at the next edge.
// Assumes soft_lvl and rest_lvl come from level encoders on the same register.
module irq_sel_core
    import irq_prio_pkg::*;
#(
    parameter  int LW = 4,
    parameter  int TW = 3
) (
    input  logic [NUM_CLASSES-1:0] pend,
    input  logic                   take_req,
    input  logic                   hpriv,
    input  logic                   tlz_en,
    input  logic [TW-1:0]          trap_level,
    input  logic                   hv_tick_ok,
    input  logic [LW-1:0]          proc_level,
    input  logic [LW-1:0]          soft_lvl,
    input  logic [LW-1:0]          rest_lvl,
    output logic                   grant_valid,
    output cause_e                 grant_cause,
    output logic [LW-1:0]          grant_level,
    output logic [NUM_CLASSES-1:0] clr_mask
);
    logic tick_ok, vec_ok, tlz_ok, cpu_ok, dev_ok, soft_ok, rerr_ok;

    // Per-class takeability, including each class's side condition.
    always_comb begin
        tick_ok = pend[C_TICK] && hv_tick_ok;
        vec_ok  = pend[C_VEC];
        tlz_ok  = pend[C_TLZ] && tlz_en && (trap_level == '0);
        cpu_ok  = pend[C_CPUQ];
        dev_ok  = pend[C_DEVQ];
        soft_ok = pend[C_SOFT] && (soft_lvl != '0) && (soft_lvl > proc_level);
        rerr_ok = pend[C_RERR];
    end

    // Priority selection: the order depends on the privilege mode.
    always_comb begin
        grant_valid = 1'b0;
        grant_cause = C_TICK;
        grant_level = '0;
        if (take_req) begin
            if (hpriv) begin
                if (tick_ok) begin
                    grant_valid = 1'b1; grant_cause = C_TICK;
                end else if (vec_ok) begin
                    grant_valid = 1'b1; grant_cause = C_VEC;
                end
            end else begin
                if (tlz_ok) begin
                    grant_valid = 1'b1; grant_cause = C_TLZ;
                end else if (tick_ok) begin
                    grant_valid = 1'b1; grant_cause = C_TICK;
                end else if (cpu_ok) begin
                    grant_valid = 1'b1; grant_cause = C_CPUQ;
                end else if (dev_ok) begin
                    grant_valid = 1'b1; grant_cause = C_DEVQ;
                end else if (soft_ok) begin
                    grant_valid = 1'b1; grant_cause = C_SOFT;
                    grant_level = soft_lvl;
                end else if (rerr_ok) begin
                    grant_valid = 1'b1; grant_cause = C_RERR;
                end
            end
        end
    end

    // Consume mask: the granted class, except a software grant with levels left.
    always_comb begin
        for (int i = 0; i < NUM_CLASSES; i++) begin
            clr_mask[i] = grant_valid && (grant_cause == cause_e'(CW'(i)));
        end
        if (rest_lvl != '0)
            clr_mask[C_SOFT] = 1'b0;
    end
endmodule

// File: rtl/irq_prio_sel.sv
// Top of the privilege-aware interrupt priority selector. It decodes posts,
// stores the pending flags, encodes software levels and drives the grant.
// Assumes that processor state inputs are stable during a take request.
module irq_prio_sel
    import irq_prio_pkg::*;
#(
    parameter  int SOFT_W = 16,
    parameter  int TL_W   = 3,
    parameter  int HVP_W  = 16,
    localparam int LVL_W  = $clog2(SOFT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              post_valid,
    input  logic [CW-1:0]     post_class,
    output logic              post_err,
    input  logic              take_req,
    input  logic              hpriv,
    input  logic              tlz_en,
    input  logic [TL_W-1:0]   trap_level,
    input  logic [HVP_W-1:0]  hv_pend,
    input  logic [LVL_W-1:0]  proc_level,
    input  logic [SOFT_W-1:0] soft_reg,
    output logic              grant_valid,
    output logic [CW-1:0]     grant_cause,
    output logic [LVL_W-1:0]  grant_level
);
    localparam logic [CW-1:0] LAST_CODE = CW'(NUM_CLASSES - 1);

    logic [NUM_CLASSES-1:0] set_mask;
    logic [NUM_CLASSES-1:0] clr_mask;
    logic [NUM_CLASSES-1:0] pend;
    logic [SOFT_W-1:0]      rest_vec;
    logic [LVL_W-1:0]       soft_lvl;
    logic [LVL_W-1:0]       rest_lvl;
    cause_e                 sel_cause;

    // Post decode: reject unknown codes, otherwise set that class.
    always_comb begin
        post_err = post_valid && (post_class > LAST_CODE);
        for (int i = 0; i < NUM_CLASSES; i++) begin
            set_mask[i] = post_valid && !post_err && (post_class == CW'(i));
        end
    end

    irq_pend_bank #(.N(NUM_CLASSES)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (set_mask),
        .clr_mask (clr_mask),
        .pend     (pend)
    );

    irq_level_enc #(.W(SOFT_W)) u_lvl_top (
        .vec (soft_reg),
        .lvl (soft_lvl)
    );

    // Software register with the level about to be taken removed.
    always_comb begin
        rest_vec = soft_reg;
        rest_vec[soft_lvl] = 1'b0;
    end

    irq_level_enc #(.W(SOFT_W)) u_lvl_rest (
        .vec (rest_vec),
        .lvl (rest_lvl)
    );

    irq_sel_core #(.LW(LVL_W), .TW(TL_W)) u_core (
        .pend        (pend),
        .take_req    (take_req),
        .hpriv       (hpriv),
        .tlz_en      (tlz_en),
        .trap_level  (trap_level),
        .hv_tick_ok  (hv_pend[0]),
        .proc_level  (proc_level),
        .soft_lvl    (soft_lvl),
        .rest_lvl    (rest_lvl),
        .grant_valid (grant_valid),
        .grant_cause (sel_cause),
        .grant_level (grant_level),
        .clr_mask    (clr_mask)
    );

    // Present the chosen code, forced to 0 when nothing is granted.
    always_comb begin
        grant_cause = grant_valid ? sel_cause : '0;
    end
endmodule

// File: rtl/irq_prio_sel_chk.sv
// Property checker for irq_prio_sel, attached by bind. It reads the ports
// and the pending flags; it drives nothing.
module irq_prio_sel_chk
    import irq_prio_pkg::*;
#(
    parameter  int SOFT_W = 16,
    parameter  int TL_W   = 3,
    parameter  int HVP_W  = 16,
    localparam int LVL_W  = $clog2(SOFT_W)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   post_valid,
    input logic [CW-1:0]          post_class,
    input logic                   post_err,
    input logic                   take_req,
    input logic                   hpriv,
    input logic                   tlz_en,
    input logic [TL_W-1:0]        trap_level,
    input logic [HVP_W-1:0]       hv_pend,
    input logic [LVL_W-1:0]       proc_level,
    input logic                   grant_valid,
    input logic [CW-1:0]          grant_cause,
    input logic [LVL_W-1:0]       grant_level,
    input logic [NUM_CLASSES-1:0] pend
);
    AST_NO_REQ_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        !take_req |-> !grant_valid);                                        // R2
    AST_HPRIV_TWO_CLASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && hpriv) |-> (grant_cause == C_TICK || grant_cause == C_VEC)); // R3
    AST_NO_VEC_UNPRIV: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !hpriv) |-> (grant_cause != C_VEC));                // R4
    AST_TICK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && grant_cause == C_TICK) |-> hv_pend[0]);             // R5
    AST_TLZ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && grant_cause == C_TLZ) |-> (tlz_en && trap_level == '0)); // R5
    AST_SOFT_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && grant_cause == C_SOFT) |-> (grant_level > proc_level)); // R6
    AST_LEVEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && grant_cause != C_SOFT) |-> (grant_level == '0));    // R6
    AST_GRANT_HAD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> pend[grant_cause]);                                 // R8
    AST_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && grant_cause != C_SOFT && !(post_valid && post_class == grant_cause))
        |=> !pend[$past(grant_cause)]);                                     // R8
    AST_POST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (post_valid && !post_err) |=> pend[$past(post_class)]);             // R9
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !$past(rst_n)) |-> (pend == '0));                         // R10
endmodule

bind irq_prio_sel irq_prio_sel_chk #(
    .SOFT_W (SOFT_W),
    .TL_W   (TL_W),
    .HVP_W  (HVP_W)
) u_chk (.*);

// File: tb/irq_prio_sel_test.sv
`timescale 1ns/1ps
// Directed bench for irq_prio_sel: one task per scenario, each checking itself.
module irq_prio_sel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        post_valid = 1'b0;
    logic [2:0]  post_class = '0;
    logic        post_err;
    logic        take_req = 1'b0;
    logic        hpriv = 1'b0;
    logic        tlz_en = 1'b1;
    logic [2:0]  trap_level = '0;
    logic [15:0] hv_pend = 16'h0001;
    logic [3:0]  proc_level = '0;
    logic [15:0] soft_reg = '0;
    logic        grant_valid;
    logic [2:0]  grant_cause;
    logic [3:0]  grant_level;

    int total = 0;
    int bad   = 0;

    localparam int TICK = 0, VEC = 1, TLZ = 2, CPUQ = 3, DEVQ = 4, SOFT = 5, RERR = 6;

    always #4 clk = ~clk;

    irq_prio_sel uut (.*);

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic post(input int c);
        post_valid = 1'b1; post_class = 3'(c);
        tick();
        post_valid = 1'b0;
    endtask

    // Request once, compare the same-cycle grant, then let the edge consume.
    task automatic take(input string tag, input bit v, input int c, input int l);
        take_req = 1'b1;
        #1;
        total++;
        if (grant_valid !== v || grant_cause !== 3'(c) || grant_level !== 4'(l)) begin
            bad++;
            $display("FAIL %s: actual v=%0b c=%0d l=%0d expected v=%0b c=%0d l=%0d",
                     tag, grant_valid, grant_cause, grant_level, v, c, l);
        end
        tick();
        take_req = 1'b0;
    endtask

    task automatic t_reset();
        take("R10 empty after reset", 0, 0, 0);
        post(TICK); post(CPUQ); post(RERR);
        rst_n = 1'b0; tick(); rst_n = 1'b1;
        take("R10 mid-run reset clears flags", 0, 0, 0);
        take("R2 no class takeable", 0, 0, 0);
    endtask

    task automatic t_bad_post();
        post_valid = 1'b1; post_class = 3'd7; #1;
        total++;
        if (post_err !== 1'b1) begin
            bad++; $display("FAIL R1 code 7 error: actual=%0b expected=1", post_err);
        end
        tick(); post_valid = 1'b0;
        take("R1 code 7 sets nothing", 0, 0, 0);
        post_valid = 1'b1; post_class = 3'(DEVQ); #1;
        total++;
        if (post_err !== 1'b0) begin
            bad++; $display("FAIL R1 legal post error: actual=%0b expected=0", post_err);
        end
        tick(); post_valid = 1'b0;
        take("R1 legal post sets flag", 1, DEVQ, 0);
        take("R8 flag consumed", 0, 0, 0);
    endtask

    task automatic t_hpriv();
        post(TICK); post(VEC); post(CPUQ);
        hpriv = 1'b1; hv_pend = 16'h0002;
        take("R5 tick blocked, R3 vector next", 1, VEC, 0);
        hv_pend = 16'h0001;
        take("R3 tick first in hypervisor mode", 1, TICK, 0);
        take("R3 CPU queue ignored in hypervisor mode", 0, 0, 0);
        hpriv = 1'b0;
        take("R4 CPU queue after leaving hypervisor mode", 1, CPUQ, 0);
    endtask

    task automatic t_order();
        soft_reg = 16'h0010;
        post(RERR); post(SOFT); post(DEVQ); post(CPUQ); post(TICK); post(TLZ);
        take("R4 order 1 trap-level-zero", 1, TLZ, 0);
        take("R4 order 2 tick", 1, TICK, 0);
        take("R4 order 3 CPU queue", 1, CPUQ, 0);
        take("R4 order 4 device queue", 1, DEVQ, 0);
        take("R4 order 5 software level 4", 1, SOFT, 4);
        take("R4 order 6 resumable error", 1, RERR, 0);
        take("R8 all consumed", 0, 0, 0);
        soft_reg = '0;
        post(VEC);
        take("R4 vector never granted unprivileged", 0, 0, 0);
        hpriv = 1'b1;
        take("R3 vector drained", 1, VEC, 0);
        hpriv = 1'b0;
    endtask

    task automatic t_gates();
        post(TLZ); post(RERR);
        tlz_en = 1'b0;
        take("R5 trap-level-zero disabled, lower class wins", 1, RERR, 0);
        tlz_en = 1'b1; trap_level = 3'd1;
        take("R5 trap-level-zero needs level 0", 0, 0, 0);
        trap_level = 3'd0;
        take("R5 trap-level-zero granted", 1, TLZ, 0);
    endtask

    task automatic t_soft();
        soft_reg = 16'h0208; proc_level = 4'd9;
        post(SOFT);
        take("R6 level equal to threshold refused", 0, 0, 0);
        proc_level = 4'd8;
        take("R6 level 9 above threshold", 1, SOFT, 9);
        soft_reg = 16'h0008; proc_level = 4'd2;
        take("R7 flag kept, level 3 next", 1, SOFT, 3);
        take("R7 flag cleared after last level", 0, 0, 0);
        soft_reg = 16'h0001; proc_level = 4'd0;
        post(SOFT);
        take("R6 bit 0 is not a level", 0, 0, 0);
        soft_reg = 16'h8000; proc_level = 4'd14;
        take("R6 top level 15", 1, SOFT, 15);
        take("R7 single level consumed", 0, 0, 0);
        soft_reg = '0; proc_level = '0;
    endtask

    task automatic t_collide();
        post(CPUQ);
        post_valid = 1'b1; post_class = 3'(CPUQ);
        take("R9 grant during repost", 1, CPUQ, 0);
        post_valid = 1'b0;
        take("R9 repost kept the flag", 1, CPUQ, 0);
        take("R8 one grant per post", 0, 0, 0);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_bad_post();
        t_hpriv();
        t_order();
        t_gates();
        t_soft();
        t_collide();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule